// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular reorder buffer for a dynamically scheduled core. Instructions enter in program order through an allocate port. Each one receives its slot number, and that number serves as the destination tag that reservation stations and execution units use. Execution units write results back by tag in any order. A result write only fills the entry: it records the value, the done flag and, for branches, whether the branch was mispredicted. No architectural state changes at that point.

Retirement happens only at the oldest end of the queue. When the oldest entry is done it retires. An ALU entry drives a register-file write, a store entry releases its memory write, and a branch entry simply leaves. With the `DUAL_COMMIT` parameter set, the next-oldest entry may retire in the same cycle, but only when the oldest one also retires. A mispredicted branch that reaches the oldest position retires alone. It raises a one-cycle flush carrying the redirect address and discards every younger entry.

A per-register producer table records which in-flight entry will write each architectural register. Consumers look it up through a query port. A retirement clears a register's mark only if the mark still names the retiring entry. A flush clears every mark.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, no retire lane is valid, `flush` is 0 and no register is marked busy.
- R2: Successive allocations return tags that count up by one modulo DEPTH. When DEPTH entries are live, `alloc_ready` is 0 and a request on `alloc_valid` is ignored, so the next tag handed out after a slot frees is the one that was refused.
- R3: A result write (`wb_valid`) marks its entry done without producing any retire output. Entries completed out of order retire only after every older entry has retired.
- R4: A done ALU entry (kind code 0) at the oldest position retires on lane 0 with `cmt_reg_we` set, its destination register on `cmt_dest` and its result on `cmt_value`.
- R5: A store entry (kind code 1) retires with `cmt_store_go` set and `cmt_reg_we` clear. Allocating a store does not mark its destination busy.
- R6: Lane 1 (upper field of each `cmt_*` bus) retires the second-oldest entry only when lane 0 retires in the same cycle, that entry is done, and it is not a mispredicted branch.
- R7: When a done branch (kind code 2) with its mispredict flag set is oldest, it retires alone on lane 0 with `flush` high for exactly that cycle. `flush_target` carries the value written back for the branch. All younger entries are dropped without retiring, and the next allocation gets the tag just after the branch.
- R8: An allocation and a retirement are both accepted in the same cycle.
- R9: The query port reports busy with the tag of the youngest in-flight ALU producer of a register. Retiring an older producer of that register leaves the mark in place, retiring the named producer clears it, and a flush clears all marks.
- R10: A correctly predicted branch (kind code 2, mispredict flag clear) retires with no register write, no store release and no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate one entry |
| alloc_kind | input | 2 | Entry kind: 0 ALU, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination architectural register |
| alloc_ready | output | 1 | A free slot exists and no flush is in progress |
| alloc_tag | output | TAG_W | Tag given to the entry allocated this cycle |
| wb_valid | input | 1 | Result write-back strobe |
| wb_tag | input | TAG_W | Entry being completed |
| wb_value | input | DATA_W | Result value, or redirect address for a branch |
| wb_mispredict | input | 1 | Branch turned out mispredicted |
| qry_reg | input | REG_W | Register looked up in the producer table |
| qry_busy | output | 1 | Register has an in-flight producer |
| qry_tag | output | TAG_W | Tag of that producer |
| cmt_valid | output | 2 | Per-lane retire strobe |
| cmt_reg_we | output | 2 | Per-lane register-file write enable |
| cmt_store_go | output | 2 | Per-lane store release |
| cmt_tag | output | 2*TAG_W | Per-lane retiring tag |
| cmt_dest | output | 2*REG_W | Per-lane destination register |
| cmt_value | output | 2*DATA_W | Per-lane result value |
| flush | output | 1 | One-cycle squash of all younger entries |
| flush_target | output | DATA_W | Correct-path redirect address |

## Verification
Retirement is driven with results that arrive in reverse program order, which separates a buffer that really waits for the oldest entry from one that retires whatever is done. It is also driven with results in program order, which shows when both lanes retire together and when lane 1 must hold back. A fill to capacity that wraps the tag counter checks refusal at full and the slot reuse after a free. A run where a mispredicted branch sits behind a done entry, with its younger entries already complete, separates a correct squash from a leak of younger results. Correct branches, stores and a producer register written twice tell apart the kind-specific retire actions and the match-only clearing of the producer table.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        K_ALU    = 2'd0,
        K_STORE  = 2'd1,
        K_BRANCH = 2'd2
    } rob_kind_e;

    localparam int RETIRE_LANES = 2;

    function automatic logic kind_writes_reg(rob_kind_e k);
        return k == K_ALU;
    endfunction

    function automatic logic [1:0] lanes_fired(logic [1:0] go);
        return {1'b0, go[0]} + {1'b0, go[1]};
    endfunction

endpackage

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
    parameter int DUAL_COMMIT = 1
) (
    input  logic       have0,
    input  logic       done0,
    input  logic       mis0,
    input  logic       have1,
    input  logic       done1,
    input  logic       mis1,
    output logic [1:0] go,
    output logic       squash
);
    logic go0;

    assign go0    = have0 && done0;
    assign squash = go0 && mis0;
    assign go[0]  = go0;

    generate
        if (DUAL_COMMIT != 0) begin : g_dual
            assign go[1] = go0 && !mis0 && have1 && done1 && !mis1;
        end else begin : g_single
            logic unused_ok;
            assign unused_ok = have1 ^ done1 ^ mis1;
            assign go[1] = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/rob_tag_table.sv
module rob_tag_table #(
    parameter int NREGS = 32,
    parameter int TAG_W = 3,
    localparam int REG_W = $clog2(NREGS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic [REG_W-1:0]   set_reg,
    input  logic [TAG_W-1:0]   set_tag,
    input  logic [1:0]         clr_en,
    input  logic [2*REG_W-1:0] clr_reg,
    input  logic [2*TAG_W-1:0] clr_tag,
    input  logic               squash,
    input  logic [REG_W-1:0]   qry_reg,
    output logic               qry_busy,
    output logic [TAG_W-1:0]   qry_tag
);
    logic [NREGS-1:0] busy_q;
    logic [TAG_W-1:0] tag_q [NREGS];

    generate
        for (genvar r = 0; r < NREGS; r++) begin : g_reg
            logic clr_hit;
            always_comb begin
                clr_hit = 1'b0;
                for (int l = 0; l < 2; l++) begin
                    if (clr_en[l] && clr_reg[l*REG_W +: REG_W] == REG_W'(r)
                        && tag_q[r] == clr_tag[l*TAG_W +: TAG_W])
                        clr_hit = 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst || squash) begin
                    busy_q[r] <= 1'b0;
                    tag_q[r]  <= '0;
                end else if (set_en && set_reg == REG_W'(r)) begin
                    busy_q[r] <= 1'b1;
                    tag_q[r]  <= set_tag;
                end else if (busy_q[r] && clr_hit) begin
                    busy_q[r] <= 1'b0;
                end
            end
        end
    endgenerate

    assign qry_busy = busy_q[qry_reg];
    assign qry_tag  = tag_q[qry_reg];
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int DATA_W      = 32,
    parameter int NREGS       = 32,
    parameter int DUAL_COMMIT = 1,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int REG_W = $clog2(NREGS),
    localparam int CNT_W = TAG_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_valid,
    input  logic [1:0]            alloc_kind,
    input  logic [REG_W-1:0]      alloc_dest,
    output logic                  alloc_ready,
    output logic [TAG_W-1:0]      alloc_tag,
    input  logic                  wb_valid,
    input  logic [TAG_W-1:0]      wb_tag,
    input  logic [DATA_W-1:0]     wb_value,
    input  logic                  wb_mispredict,
    input  logic [REG_W-1:0]      qry_reg,
    output logic                  qry_busy,
    output logic [TAG_W-1:0]      qry_tag,
    output logic [1:0]            cmt_valid,
    output logic [1:0]            cmt_reg_we,
    output logic [1:0]            cmt_store_go,
    output logic [2*TAG_W-1:0]    cmt_tag,
    output logic [2*REG_W-1:0]    cmt_dest,
    output logic [2*DATA_W-1:0]   cmt_value,
    output logic                  flush,
    output logic [DATA_W-1:0]     flush_target
);
    typedef struct packed {
        logic             valid;
        logic             done;
        logic             mispred;
        rob_kind_e        kind;
        logic [REG_W-1:0] dest;
        logic [DATA_W-1:0] value;
    } entry_t;

    entry_t            ent_q [DEPTH];
    logic [TAG_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [TAG_W-1:0]  lane_ptr [RETIRE_LANES];
    logic [1:0]        go;
    logic [1:0]        n_ret;
    logic              alloc_fire;

    assign alloc_ready = (cnt_q != CNT_W'(DEPTH)) && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_q;
    assign n_ret       = lanes_fired(go);

    generate
        for (genvar l = 0; l < RETIRE_LANES; l++) begin : g_lane
            entry_t e;
            assign lane_ptr[l] = head_q + TAG_W'(l);
            assign e = ent_q[lane_ptr[l]];
            assign cmt_valid[l]    = go[l];
            assign cmt_reg_we[l]   = go[l] && kind_writes_reg(e.kind);
            assign cmt_store_go[l] = go[l] && (e.kind == K_STORE);
            assign cmt_tag[l*TAG_W +: TAG_W]     = lane_ptr[l];
            assign cmt_dest[l*REG_W +: REG_W]    = e.dest;
            assign cmt_value[l*DATA_W +: DATA_W] = e.value;
        end
    endgenerate

    rob_retire_sel #(.DUAL_COMMIT(DUAL_COMMIT)) i_sel (
        .have0  (cnt_q != '0),
        .done0  (ent_q[lane_ptr[0]].done),
        .mis0   (ent_q[lane_ptr[0]].mispred),
        .have1  (cnt_q > CNT_W'(1)),
        .done1  (ent_q[lane_ptr[1]].done),
        .mis1   (ent_q[lane_ptr[1]].mispred),
        .go     (go),
        .squash (flush)
    );

    assign flush_target = ent_q[head_q].value;

    rob_tag_table #(.NREGS(NREGS), .TAG_W(TAG_W)) i_tags (
        .clk      (clk),
        .rst      (rst),
        .set_en   (alloc_fire && kind_writes_reg(rob_kind_e'(alloc_kind))),
        .set_reg  (alloc_dest),
        .set_tag  (tail_q),
        .clr_en   (cmt_reg_we),
        .clr_reg  (cmt_dest),
        .clr_tag  (cmt_tag),
        .squash   (flush),
        .qry_reg  (qry_reg),
        .qry_busy (qry_busy),
        .qry_tag  (qry_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (flush) begin
            head_q <= head_q + TAG_W'(1);
            tail_q <= head_q + TAG_W'(1);
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_q[i].valid <= 1'b0;
                ent_q[i].done  <= 1'b0;
            end
        end else begin
            head_q <= head_q + TAG_W'(n_ret);
            tail_q <= tail_q + TAG_W'(alloc_fire);
            cnt_q  <= cnt_q + CNT_W'(alloc_fire) - CNT_W'(n_ret);
            for (int l = 0; l < RETIRE_LANES; l++) begin
                if (go[l]) begin
                    ent_q[lane_ptr[l]].valid <= 1'b0;
                    ent_q[lane_ptr[l]].done  <= 1'b0;
                end
            end
            if (wb_valid && ent_q[wb_tag].valid) begin
                ent_q[wb_tag].done    <= 1'b1;
                ent_q[wb_tag].value   <= wb_value;
                ent_q[wb_tag].mispred <= wb_mispredict;
            end
            if (alloc_fire) begin
                ent_q[tail_q].valid   <= 1'b1;
                ent_q[tail_q].done    <= 1'b0;
                ent_q[tail_q].mispred <= 1'b0;
                ent_q[tail_q].kind    <= rob_kind_e'(alloc_kind);
                ent_q[tail_q].dest    <= alloc_dest;
                ent_q[tail_q].value   <= '0;
            end
        end
    end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] cnt,
    input logic             alloc_ready,
    input logic [1:0]       cmt_valid,
    input logic [1:0]       cmt_reg_we,
    input logic [1:0]       cmt_store_go,
    input logic             flush
);
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    p_full_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(DEPTH)) |-> !alloc_ready);

    p_store_no_regwrite_r5: assert property (@(posedge clk) disable iff (rst)
        (cmt_store_go & cmt_reg_we) == 2'b00);

    p_lane1_needs_lane0_r6: assert property (@(posedge clk) disable iff (rst)
        cmt_valid[1] |-> cmt_valid[0]);

    p_flush_alone_r7: assert property (@(posedge clk) disable iff (rst)
        flush |-> (cmt_valid == 2'b01));

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt == '0) && !flush);
endmodule

bind rob_core rob_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_rob_chk (
    .clk          (clk),
    .rst          (rst),
    .cnt          (cnt_q),
    .alloc_ready  (alloc_ready),
    .cmt_valid    (cmt_valid),
    .cmt_reg_we   (cmt_reg_we),
    .cmt_store_go (cmt_store_go),
    .flush        (flush)
);

// File: tb/test_rob_core.sv
module test_rob_core;
    localparam int DEPTH = 8;
    localparam int TW = 3;
    localparam int RW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_valid = 1'b0;
    logic [1:0] alloc_kind = 2'd0;
    logic [RW-1:0] alloc_dest = '0;
    logic alloc_ready;
    logic [TW-1:0] alloc_tag;
    logic wb_valid = 1'b0;
    logic [TW-1:0] wb_tag = '0;
    logic [DW-1:0] wb_value = '0;
    logic wb_mispredict = 1'b0;
    logic [RW-1:0] qry_reg = '0;
    logic qry_busy;
    logic [TW-1:0] qry_tag;
    logic [1:0] cmt_valid, cmt_reg_we, cmt_store_go;
    logic [2*TW-1:0] cmt_tag;
    logic [2*RW-1:0] cmt_dest;
    logic [2*DW-1:0] cmt_value;
    logic flush;
    logic [DW-1:0] flush_target;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .DATA_W(DW), .NREGS(32), .DUAL_COMMIT(1)) i_rob_core (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_mispredict(wb_mispredict),
        .qry_reg(qry_reg), .qry_busy(qry_busy), .qry_tag(qry_tag),
        .cmt_valid(cmt_valid), .cmt_reg_we(cmt_reg_we), .cmt_store_go(cmt_store_go),
        .cmt_tag(cmt_tag), .cmt_dest(cmt_dest), .cmt_value(cmt_value),
        .flush(flush), .flush_target(flush_target)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic alloc1(input logic [1:0] k, input logic [RW-1:0] d, output logic [TW-1:0] t);
        alloc_valid = 1'b1; alloc_kind = k; alloc_dest = d;
        #1 t = alloc_tag;
        @(posedge clk); #2;
        alloc_valid = 1'b0;
    endtask

    task automatic wb1(input logic [TW-1:0] t, input logic [DW-1:0] v, input logic m);
        wb_valid = 1'b1; wb_tag = t; wb_value = v; wb_mispredict = m;
        @(posedge clk); #2;
        wb_valid = 1'b0; wb_mispredict = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1", "alloc_ready", 32'(alloc_ready), 32'd1);
        check("R1", "alloc_tag", 32'(alloc_tag), 32'd0);
        check("R1", "cmt_valid", 32'(cmt_valid), 32'd0);
        check("R1", "flush", 32'(flush), 32'd0);
        check("R1", "qry_busy", 32'(qry_busy), 32'd0);
    endtask

    task automatic t_out_of_order();
        logic [TW-1:0] a, b, c;
        alloc1(2'd0, 5'd5, a);
        alloc1(2'd0, 5'd6, b);
        alloc1(2'd0, 5'd5, c);
        check("R2", "tag sequence", {a, b, c}, {3'd0, 3'd1, 3'd2});
        qry_reg = 5'd5; #1;
        check("R9", "reg5 busy", 32'(qry_busy), 32'd1);
        check("R9", "reg5 youngest tag", 32'(qry_tag), 32'd2);
        wb1(c, 32'hC0C0, 1'b0);
        check("R3", "no retire, youngest done", 32'(cmt_valid), 32'd0);
        wb1(b, 32'hB0B0, 1'b0);
        check("R3", "no retire, head not done", 32'(cmt_valid), 32'd0);
        wb1(a, 32'hA0A0, 1'b0);
        check("R6", "both lanes", 32'(cmt_valid), 32'd3);
        check("R4", "lane0 reg_we", 32'(cmt_reg_we), 32'd3);
        check("R4", "lane0 dest", 32'(cmt_dest[RW-1:0]), 32'd5);
        check("R4", "lane0 value", cmt_value[DW-1:0], 32'hA0A0);
        check("R3", "lane1 tag", 32'(cmt_tag[2*TW-1:TW]), 32'd1);
        idle(1);
        check("R3", "third retires next", 32'(cmt_valid), 32'd1);
        check("R3", "third tag", 32'(cmt_tag[TW-1:0]), 32'd2);
        check("R9", "reg5 kept after older retire", {31'd0, qry_busy}, 32'd1);
        idle(1);
        check("R9", "reg5 cleared by own retire", 32'(qry_busy), 32'd0);
        check("R3", "drained", 32'(cmt_valid), 32'd0);
    endtask

    task automatic t_store();
        logic [TW-1:0] t;
        alloc1(2'd1, 5'd9, t);
        qry_reg = 5'd9; #1;
        check("R5", "store sets no producer", 32'(qry_busy), 32'd0);
        wb1(t, 32'h5151, 1'b0);
        check("R5", "store retires", 32'(cmt_valid), 32'd1);
        check("R5", "store_go", 32'(cmt_store_go), 32'd1);
        check("R5", "no reg_we", 32'(cmt_reg_we), 32'd0);
        idle(1);
    endtask

    task automatic t_full();
        logic [TW-1:0] t;
        for (int i = 0; i < DEPTH; i++) begin
            alloc1(2'd0, RW'(i + 10), t);
            check("R2", "wrap tag", 32'(t), 32'((4 + i) % DEPTH));
        end
        #1;
        check("R2", "full not ready", 32'(alloc_ready), 32'd0);
        alloc1(2'd0, 5'd20, t);
        wb1(3'd4, 32'h44, 1'b0);
        check("R2", "still full while retiring", 32'(alloc_ready), 32'd0);
        idle(1);
        check("R2", "refused tag reused", 32'(alloc_tag), 32'd4);
        wb1(3'd5, 32'h55, 1'b0);
        alloc_valid = 1'b1; alloc_kind = 2'd0; alloc_dest = 5'd21;
        #1;
        check("R8", "retire with alloc", 32'(cmt_valid), 32'd1);
        check("R8", "alloc accepted", 32'(alloc_ready), 32'd1);
        @(posedge clk); #2;
        alloc_valid = 1'b0;
        check("R8", "tag advanced", 32'(alloc_tag), 32'd5);
        for (int i = 0; i < 7; i++) wb1(TW'(6 + i), 32'(i), 1'b0);
        idle(4);
        check("R8", "drained empty", 32'(cmt_valid), 32'd0);
        check("R8", "tail stays", 32'(alloc_tag), 32'd5);
    endtask

    task automatic t_mispredict();
        logic [TW-1:0] a, br, c, d;
        alloc1(2'd0, 5'd3, a);
        alloc1(2'd2, 5'd0, br);
        alloc1(2'd0, 5'd4, c);
        alloc1(2'd0, 5'd3, d);
        check("R2", "tags", {a, br, c, d}, {3'd5, 3'd6, 3'd7, 3'd0});
        wb1(c, 32'h77, 1'b0);
        wb1(d, 32'h88, 1'b0);
        wb1(br, 32'h1234, 1'b1);
        wb1(a, 32'h55, 1'b0);
        check("R6", "lane1 holds mispredict", 32'(cmt_valid), 32'd1);
        check("R7", "no flush yet", 32'(flush), 32'd0);
        idle(1);
        qry_reg = 5'd3; #1;
        check("R9", "reg3 kept", 32'({qry_busy, qry_tag}), 32'({1'b1, 3'd0}));
        check("R7", "flush", 32'(flush), 32'd1);
        check("R7", "flush_target", flush_target, 32'h1234);
        check("R7", "branch retires alone", 32'(cmt_valid), 32'd1);
        check("R7", "no reg write", 32'(cmt_reg_we), 32'd0);
        idle(1);
        check("R7", "one-cycle flush", 32'(flush), 32'd0);
        check("R7", "younger dropped", 32'(cmt_valid), 32'd0);
        check("R7", "next tag", 32'(alloc_tag), 32'd7);
        check("R9", "flush clears reg3", 32'(qry_busy), 32'd0);
        qry_reg = 5'd4; #1;
        check("R9", "flush clears reg4", 32'(qry_busy), 32'd0);
    endtask

    task automatic t_branch_ok();
        logic [TW-1:0] t;
        alloc1(2'd2, 5'd0, t);
        wb1(t, 32'h900, 1'b0);
        check("R10", "branch retires", 32'(cmt_valid), 32'd1);
        check("R10", "no flush", 32'(flush), 32'd0);
        check("R10", "no reg_we", 32'(cmt_reg_we), 32'd0);
        check("R10", "no store", 32'(cmt_store_go), 32'd0);
        idle(1);
        check("R10", "next tag", 32'(alloc_tag), 32'd0);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        t_out_of_order();
        t_store();
        t_full();
        t_mispredict();
        t_branch_ok();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule